// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer on a small 32-bit register bus. Software must keep reloading a 32-bit down-counter before it reaches zero. If the count runs out, the block can request a system reset, raise an interrupt, or do both. Which action it takes depends on the control word. The block records what happened in status flags that stay set until cleared.

The timer and control registers are guarded by a 16-bit unlock key. A write to either register only takes effect while the key register holds the unlock value. Writing any other value to the key register locks the block again. The usual sequence is: unlock, clear the control word, load the count, enable counting together with the chosen actions, then relock. While unlocked, software keeps the watchdog alive by rewriting the timer register.

The block has two resets. `por_n` is the power-on reset and clears everything. `sys_rst_n` is the system reset that the watchdog itself may cause. It clears every register except the warm-reset flag, so software can find out after boot why the system restarted. The register bus has no handshake: a write completes in the cycle `bus_we` is sampled high, and read data follows the address combinationally.

Top module: `wdog_keyed`

## Requirements
- R1: After `por_n` is released, the timer (0x14), control (0x18), key (0x1C) and status (0x20) registers all read zero, and `rst_req` and `irq` are low.
- R2: A write to the timer or control register takes effect only while the key register holds 0x482E. The key register stores bits 15:0 of a write to 0x1C. Any other key value locks the block, and writes to the timer or control register while locked leave them unchanged.
- R3: In the control register, bit 0 enables the reset request, bit 1 enables the interrupt and bit 2 enables counting. An accepted write reads back the same three bits.
- R4: An accepted write to the timer register replaces the live count at that clock edge, and a read of 0x14 returns the live count.
- R5: While the count-enable bit is set and the count is nonzero, the count drops by one each clock. With count-enable clear, the count holds its value.
- R6: When a decrement takes the count from 1 to 0, status bit 3 (pending) sets and the count then stays at zero.
- R7: If reset-enable is set at that expiry, `rst_req` is high for exactly 16 consecutive clocks, starting in the cycle the count reads zero, and status bit 4 (warm reset) sets.
- R8: `irq` is a level that is high while pending is set and interrupt-enable is set. It stays high until software clears pending.
- R9: Writing a 1 to status bit 3 or bit 4 clears that bit, whether the block is locked or unlocked. Writing a 0 to a status bit leaves it unchanged.
- R10: `sys_rst_n` clears the count, control, key, pending flag and reset request, but leaves the warm-reset flag unchanged. Only `por_n` clears the warm-reset flag.
- R11: Addresses other than the four registers read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears all state |
| sys_rst_n | input | 1 | Asynchronous system reset, active low; clears all state except the warm-reset flag |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | System reset request pulse |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters:
- a 32-bit count;
- an 8-bit address;
- a 16-clock reset pulse.

Because the timer takes any count value, the bench loads counts of a few units. This makes expiry, the stop at zero and the whole reset pulse reachable within a few dozen cycles, and each can be checked at the exact clock it is due. The bench acts as the external reset controller by driving `sys_rst_n` after a pulse, which shows that the warm-reset flag survives that reset.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] OFF_TIMER = 8'h14;
  localparam logic [7:0] OFF_CTRL  = 8'h18;
  localparam logic [7:0] OFF_KEY   = 8'h1C;
  localparam logic [7:0] OFF_STAT  = 8'h20;

  localparam int STAT_PEND = 3;
  localparam int STAT_WARM = 4;

  localparam logic [15:0] UNLOCK_KEY = 16'h482E;

  // Field order matches control register bits 2..0
  typedef struct packed {
    logic cnt_en;
    logic irq_en;
    logic rst_en;
  } ctrl_t;
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  count <= '0;
    else if (load)               count <= load_val;
    else if (run && count != '0) count <= count - ONE;
  end

  // Expiry is the step from one to zero; a load in the same cycle wins
  assign expire = run && !load && (count == ONE);
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam int W = $clog2(LEN + 1);
  logic [W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left <= '0;
    else if (start)        left <= W'(LEN);
    else if (left != '0)   left <= left - W'(1);
  end

  assign active = (left != '0);
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int KEY_W  = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic              expire,
  input  logic [CNT_W-1:0]  count,
  output ctrl_t             ctrl,
  output logic              load_en,
  output logic              unlocked,
  output logic              pending,
  output logic              warm,
  output logic [DATA_W-1:0] rdata
);
  logic [KEY_W-1:0] key_q;
  logic sel_timer, sel_ctrl, sel_key, sel_stat;
  logic unused_hi;

  assign unused_hi = ^wdata[DATA_W-1:KEY_W];

  assign sel_timer = (addr == ADDR_W'(OFF_TIMER));
  assign sel_ctrl  = (addr == ADDR_W'(OFF_CTRL));
  assign sel_key   = (addr == ADDR_W'(OFF_KEY));
  assign sel_stat  = (addr == ADDR_W'(OFF_STAT));

  assign unlocked = (key_q == KEY_W'(UNLOCK_KEY));
  assign load_en  = we && sel_timer && unlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q   <= '0;
      ctrl    <= '0;
      pending <= 1'b0;
    end else begin
      if (we && sel_key)              key_q <= wdata[KEY_W-1:0];
      if (we && sel_ctrl && unlocked) ctrl  <= ctrl_t'(wdata[2:0]);
      if (expire)                                     pending <= 1'b1;
      else if (we && sel_stat && wdata[STAT_PEND])    pending <= 1'b0;
    end
  end

  // Warm-reset flag lives in the power-on domain only
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                                    warm <= 1'b0;
    else if (expire && ctrl.rst_en)                warm <= 1'b1;
    else if (we && sel_stat && wdata[STAT_WARM])   warm <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    if (sel_timer)     rdata = DATA_W'(count);
    else if (sel_ctrl) rdata = DATA_W'(ctrl);
    else if (sel_key)  rdata = DATA_W'(key_q);
    else if (sel_stat) begin
      rdata[STAT_PEND] = pending;
      rdata[STAT_WARM] = warm;
    end
  end
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 32,
  parameter int RST_PULSE = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  output logic              rst_req,
  output logic              irq
);
  localparam int DATA_W = 32;

  logic             soft_rst_n;
  ctrl_t            ctrl_q;
  logic             load_en, unlocked, pending, warm, expire;
  logic [CNT_W-1:0] cnt_q;

  assign soft_rst_n = por_n & sys_rst_n;

  wdog_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .KEY_W(16)
  ) u_regs (
    .clk(clk), .por_n(por_n), .rst_n(soft_rst_n),
    .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
    .expire(expire), .count(cnt_q),
    .ctrl(ctrl_q), .load_en(load_en), .unlocked(unlocked),
    .pending(pending), .warm(warm), .rdata(bus_rdata)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(soft_rst_n),
    .load(load_en), .load_val(bus_wdata[CNT_W-1:0]),
    .run(ctrl_q.cnt_en), .count(cnt_q), .expire(expire)
  );

  wdog_pulse #(.LEN(RST_PULSE)) u_pulse (
    .clk(clk), .rst_n(soft_rst_n),
    .start(expire && ctrl_q.rst_en), .active(rst_req)
  );

  assign irq = pending & ctrl_q.irq_en;
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk
  import wdog_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 32,
  parameter int PULSE_LEN = 16
) (
  input logic              clk,
  input logic              por_n,
  input logic              sys_rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              wd_pend,
  input logic              wd_warm,
  input logic              rst_req,
  input logic              irq,
  input logic [CNT_W-1:0]  count,
  input logic [2:0]        ctrl,
  input logic              unlocked,
  input logic              pending,
  input logic              warm
);
  localparam int RW = $clog2(PULSE_LEN + 2);
  logic [RW-1:0] run_len;
  logic          all_rst_n, tload, ctrl_wr, clr_pend, clr_warm;

  assign all_rst_n = por_n & sys_rst_n;
  assign tload     = bus_we && unlocked && bus_addr == ADDR_W'(OFF_TIMER);
  assign ctrl_wr   = bus_we && bus_addr == ADDR_W'(OFF_CTRL);
  assign clr_pend  = bus_we && bus_addr == ADDR_W'(OFF_STAT) && wd_pend;
  assign clr_warm  = bus_we && bus_addr == ADDR_W'(OFF_STAT) && wd_warm;

  always_ff @(posedge clk or negedge all_rst_n) begin
    if (!all_rst_n)   run_len <= '0;
    else if (rst_req) run_len <= run_len + RW'(1);
    else              run_len <= '0;
  end

  a_r2_ctrl_locked: assert property (@(posedge clk) disable iff (!all_rst_n)
    (ctrl_wr && !unlocked) |=> $stable(ctrl));

  a_r5_hold_when_off: assert property (@(posedge clk) disable iff (!all_rst_n)
    (!ctrl[2] && !tload) |=> $stable(count));

  a_r6_zero_sticks: assert property (@(posedge clk) disable iff (!all_rst_n)
    (count == '0 && !tload) |=> (count == '0));

  a_r6_pending_set: assert property (@(posedge clk) disable iff (!all_rst_n)
    (ctrl[2] && count == CNT_W'(1) && !tload) |=> pending);

  a_r7_pulse_len: assert property (@(posedge clk) disable iff (!all_rst_n)
    rst_req |-> (run_len < RW'(PULSE_LEN)));

  a_r8_irq_level: assert property (@(posedge clk) disable iff (!all_rst_n)
    (irq && !clr_pend && !ctrl_wr) |=> irq);

  a_r10_warm_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (warm && !clr_warm) |=> warm);
endmodule

bind wdog_keyed wdog_keyed_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PULSE_LEN(RST_PULSE)
) u_chk (
  .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
  .bus_addr(bus_addr), .bus_we(bus_we),
  .wd_pend(bus_wdata[3]), .wd_warm(bus_wdata[4]),
  .rst_req(rst_req), .irq(irq), .count(cnt_q), .ctrl(ctrl_q),
  .unlocked(unlocked), .pending(pending), .warm(warm)
);

// File: tb/tb_wdog_keyed.sv
module tb_wdog_keyed;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_TMR = 8'h14, A_CTL = 8'h18, A_KEY = 8'h1C, A_STS = 8'h20;
  localparam logic [31:0] KEY = 32'h482E;

  logic        clk = 1'b0;
  logic        por_n = 1'b0, sys_rst_n = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        rst_req, irq;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_keyed dut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .rst_req(rst_req), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic t_reset;
    rd(A_TMR, 0, "R1 timer"); rd(A_CTL, 0, "R1 ctrl");
    rd(A_KEY, 0, "R1 key");   rd(A_STS, 0, "R1 status");
    chk("R1 rst_req", {31'b0, rst_req}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_lock;
    wr(A_CTL, 7);   rd(A_CTL, 0, "R2 ctrl locked");
    wr(A_TMR, 100); rd(A_TMR, 0, "R2 timer locked");
    wr(A_KEY, KEY); rd(A_KEY, KEY, "R2 key readback");
    wr(A_CTL, 3);   rd(A_CTL, 3, "R3 ctrl readback");
    wr(A_TMR, 50);  rd(A_TMR, 50, "R2 timer unlocked");
    wr(A_KEY, 32'h1234);
    wr(A_CTL, 0);   rd(A_CTL, 3, "R2 relocked by other key");
    wr(A_KEY, KEY); wr(A_CTL, 0); wr(A_KEY, 0);
  endtask

  task automatic t_load_count;
    wr(A_KEY, KEY); wr(A_TMR, 40); wr(A_CTL, 4);
    rd(A_TMR, 40, "R5 start");
    repeat (5) @(negedge clk);
    rd(A_TMR, 35, "R5 decrement");
    wr(A_TMR, 100); rd(A_TMR, 100, "R4 keep-alive reload");
    wr(A_CTL, 0);   rd(A_TMR, 99, "R5 last step");
    repeat (3) @(negedge clk);
    rd(A_TMR, 99, "R5 hold when disabled");
    wr(A_KEY, 0);
  endtask

  task automatic t_expire_irq;
    wr(A_KEY, KEY); wr(A_CTL, 0); wr(A_TMR, 6); wr(A_CTL, 6);
    wr(A_KEY, 0);
    repeat (4) @(negedge clk);
    rd(A_TMR, 1, "R6 count one");
    rd(A_STS, 0, "R6 not yet pending");
    chk("R8 irq before expiry", {31'b0, irq}, 0);
    @(negedge clk);
    rd(A_STS, 32'h8, "R6 pending set");
    chk("R8 irq raised", {31'b0, irq}, 1);
    chk("R7 no reset when disabled", {31'b0, rst_req}, 0);
    repeat (3) @(negedge clk);
    rd(A_TMR, 0, "R6 stays at zero");
    chk("R8 irq level", {31'b0, irq}, 1);
    wr(A_STS, 32'h10);
    rd(A_STS, 32'h8, "R9 write of other bit keeps pending");
    chk("R8 irq still high", {31'b0, irq}, 1);
    wr(A_STS, 32'h8);
    rd(A_STS, 0, "R9 cleared while locked");
    chk("R8 irq dropped", {31'b0, irq}, 0);
  endtask

  task automatic t_expire_reset;
    int hi;
    wr(A_KEY, KEY); wr(A_CTL, 0); wr(A_TMR, 3); wr(A_CTL, 5);
    wr(A_KEY, 0);
    @(negedge clk);
    chk("R7 no pulse before expiry", {31'b0, rst_req}, 0);
    @(negedge clk);
    chk("R7 pulse starts", {31'b0, rst_req}, 1);
    rd(A_STS, 32'h18, "R7 warm and pending set");
    chk("R8 irq off without enable", {31'b0, irq}, 0);
    hi = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (rst_req) hi++;
      else break;
    end
    chk("R7 pulse length", hi, 16);
    sys_rst_n = 1'b0;
    @(negedge clk);
    sys_rst_n = 1'b1;
    rd(A_STS, 32'h10, "R10 warm survives system reset");
    rd(A_CTL, 0, "R10 ctrl cleared");
    rd(A_KEY, 0, "R10 key cleared");
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    rd(A_STS, 0, "R10 power-on clears warm");
  endtask

  task automatic t_unmapped;
    wr(A_KEY, KEY); wr(A_CTL, 2);
    wr(8'h24, 32'hFFFF_FFFF); rd(8'h24, 0, "R11 unmapped reads zero");
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, 0, "R11 low address");
    rd(A_CTL, 2, "R11 ctrl untouched");
    rd(A_TMR, 0, "R11 timer untouched");
    rd(A_KEY, KEY, "R11 key untouched");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock();
    t_load_count();
    t_expire_irq();
    t_expire_reset();
    t_unmapped();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule